// File: doc/BRIEF.md
# Streaming Read Master for a 12-bit I2C Converter

This block is an I2C bus master that pulls 12-bit conversion results out of a converter slave that can only be read. After a start request it generates a start condition and sends one address byte with the read bit set. It then samples the slave's acknowledge and clocks in two-byte result frames. The upper byte of each frame carries four header bits, which should be zero, and then result bits 11 to 8. The lower byte carries result bits 7 to 0. Each frame is presented on the sample port as one 12-bit word with a single-cycle strobe.

Two modes are offered and selected when a read starts. In single-shot mode the master reads one frame, answers the lower byte with a not-acknowledge and releases the bus with a stop. In continuous mode the master acknowledges every lower byte and goes straight on to the next upper byte, with no new start and no new address. The result is a steady stream of one sample every 18 SCL periods. A stop request ends the stream at the next lower-byte acknowledge slot.

Both bus lines are driven open-drain: the block only ever pulls a line low or releases it. The SCL period is four quarter phases of `DIV_Q` system clocks each. SCL is low for the first two quarters of every bit slot. SDA changes between the first and second quarter, and the bus is sampled between the third and fourth quarter.

Top module: `adc_stream_reader`

## Requirements
- R1: After reset, and whenever no read is in progress, `scl_low`, `sda_low`, `busy` and `smp_valid` are all 0.
- R2: An accepted `go` produces a start condition (SDA falls while SCL is released). It is followed by the address byte `{DEV_CODE, DEV_SEL, 1}` sent most significant bit first. Within address and data slots, SDA changes only while SCL is driven low.
- R3: Every SCL period lasts exactly 4*`DIV_Q` system clocks, and SCL is held low for the first half of each bit slot.
- R4: If SDA is high when the address acknowledge is sampled, `addr_err` goes to 1, no sample is produced, a stop condition follows and `busy` returns to 0.
- R5: After the upper byte the master drives an acknowledge (SDA low) during the ninth clock. It then clocks eight more bits as the lower byte.
- R6: Each frame yields `smp_data = {upper[3:0], lower[7:0]}` with `smp_valid` high for exactly one cycle. `fmt_err` is 1 alongside that strobe exactly when `upper[7:4]` is non-zero.
- R7: In single-shot mode (`cont_mode` = 0 when `go` is accepted), the lower byte is answered with SDA high (not-acknowledge) and then a stop, and exactly one sample is produced.
- R8: In continuous mode (`cont_mode` = 1) the lower byte is acknowledged low and the next upper byte follows with no new start or address. Successive strobes are 18*4*`DIV_Q` system clocks apart.
- R9: A `stop_req` pulse during a continuous read is held until the next lower-byte acknowledge slot. That slot is then answered with a not-acknowledge, followed by a stop.
- R10: A `stop_req` while idle has no effect on the next read, and a `go` while a read is in progress is ignored.
- R11: `addr_err` stays set after a failed address phase and is cleared when the next `go` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a read when idle |
| cont_mode | input | 1 | Mode captured with `go`: 1 = continuous, 0 = single-shot |
| stop_req | input | 1 | End a continuous read at the next lower-byte acknowledge |
| sda_in | input | 1 | Level of the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A read is in progress |
| smp_data | output | 12 | Assembled sample |
| smp_valid | output | 1 | One-cycle strobe for `smp_data` |
| fmt_err | output | 1 | Upper header bits of this frame were non-zero (valid with strobe) |
| addr_err | output | 1 | Address was not acknowledged |

## Verification
The assertions assume that `sda_in` is already synchronous to `clk` and reflects the wired-AND of both drivers. They also assume that the slave changes SDA only while SCL is low, since the master never waits on a stretched clock. The bench keeps within these limits with an event-driven slave model. The model updates its drive only on SCL falling edges and reads the bus on SCL rising edges. `go` and `stop_req` are driven as single-cycle pulses on the falling clock edge.

// File: rtl/adc_rd_pkg.sv
// adc_rd_pkg: shared state encoding for the converter read master.
// Assumes nothing beyond being compiled before the modules that import it.
package adc_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_AACK,
        ST_UPPER,
        ST_MACK1,
        ST_LOWER,
        ST_MACK2,
        ST_STOP
    } rd_state_t;

endpackage

// File: rtl/adc_rd_phase.sv
// adc_rd_phase: divides the system clock into four quarter phases per bit slot.
// Assumes DIV_Q >= 2. While run is low the counters sit at quarter 0.
module adc_rd_phase #(
    parameter int DIV_Q = 156
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] q,
    output logic       tick
);
    localparam int CW = (DIV_Q > 2) ? $clog2(DIV_Q) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_Q - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within a quarter and step the quarter index.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            q   <= 2'd0;
        end else if (tick) begin
            cnt <= '0;
            q   <= q + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (q == $past(q)));

endmodule

// File: rtl/adc_rd_frame.sv
// adc_rd_frame: shifts in the two bytes of a frame and emits one sample.
// Assumes shift_en marks each sampled bit, with up_last/lo_last on the
// eighth bit of the upper and lower byte respectively.
module adc_rd_frame #(
    parameter int BYTE_W = 8,
    parameter int SMP_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             up_last,
    input  logic             lo_last,
    output logic [SMP_W-1:0] data,
    output logic             valid,
    output logic             fmt_err
);
    localparam int HI_W  = SMP_W - BYTE_W;
    localparam int HDR_W = BYTE_W - HI_W;

    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] up_r;
    logic [BYTE_W-1:0] nxt;

    assign nxt = {sh[BYTE_W-2:0], bit_in};

    // Shift register and upper-byte hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            up_r <= '0;
        end else if (shift_en) begin
            sh <= nxt;
            if (up_last) up_r <= nxt;
        end
    end

    // Sample word, header check and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data    <= '0;
            valid   <= 1'b0;
            fmt_err <= 1'b0;
        end else begin
            valid <= shift_en && lo_last;
            if (shift_en && lo_last) begin
                data    <= {up_r[HI_W-1:0], nxt};
                fmt_err <= |up_r[BYTE_W-1:BYTE_W-HDR_W];
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/adc_stream_reader.sv
// adc_stream_reader: I2C master reading 12-bit frames from a read-only
// converter, in single-shot or continuous mode.
// Assumes sda_in is synchronous to clk, no clock stretching and a single master.
module adc_stream_reader
    import adc_rd_pkg::*;
#(
    parameter int          DIV_Q    = 156,
    parameter logic [3:0]  DEV_CODE = 4'b1001,
    parameter logic [2:0]  DEV_SEL  = 3'b000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        cont_mode,
    input  logic        stop_req,
    input  logic        sda_in,
    output logic        scl_low,
    output logic        sda_low,
    output logic        busy,
    output logic [11:0] smp_data,
    output logic        smp_valid,
    output logic        fmt_err,
    output logic        addr_err
);
    localparam logic [7:0] ADDR_BYTE = {DEV_CODE, DEV_SEL, 1'b1};

    rd_state_t  st;
    logic [2:0] bit_n;
    logic       mode_r;
    logic       stop_pend;
    logic       keep_on;
    logic [1:0] q;
    logic       tick;
    logic       mid_low, samp, slot_end;
    logic       in_data;

    adc_rd_phase #(.DIV_Q(DIV_Q)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != ST_IDLE),
        .q    (q),
        .tick (tick)
    );

    assign mid_low  = tick && (q == 2'd0);
    assign samp     = tick && (q == 2'd2);
    assign slot_end = tick && (q == 2'd3);
    assign busy     = (st != ST_IDLE);
    assign in_data  = (st == ST_ADDR) || (st == ST_AACK) || (st == ST_UPPER) ||
                      (st == ST_MACK1) || (st == ST_LOWER) || (st == ST_MACK2);

    // SCL is pulled low in the first half of every clocked slot.
    always_comb begin
        scl_low = 1'b0;
        if (in_data || st == ST_STOP) scl_low = (q < 2'd2);
    end

    // Slot sequencer: state and bit index advance at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bit_n  <= 3'd7;
            mode_r <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    st     <= ST_START;
                    mode_r <= cont_mode;
                end
                ST_START: if (slot_end) begin
                    st    <= ST_ADDR;
                    bit_n <= 3'd7;
                end
                ST_ADDR: if (slot_end) begin
                    if (bit_n == 3'd0) st <= ST_AACK;
                    else               bit_n <= bit_n - 3'd1;
                end
                ST_AACK: if (slot_end) begin
                    if (addr_err) st <= ST_STOP;
                    else begin
                        st    <= ST_UPPER;
                        bit_n <= 3'd7;
                    end
                end
                ST_UPPER: if (slot_end) begin
                    if (bit_n == 3'd0) st <= ST_MACK1;
                    else               bit_n <= bit_n - 3'd1;
                end
                ST_MACK1: if (slot_end) begin
                    st    <= ST_LOWER;
                    bit_n <= 3'd7;
                end
                ST_LOWER: if (slot_end) begin
                    if (bit_n == 3'd0) st <= ST_MACK2;
                    else               bit_n <= bit_n - 3'd1;
                end
                ST_MACK2: if (slot_end) begin
                    if (keep_on) begin
                        st    <= ST_UPPER;
                        bit_n <= 3'd7;
                    end else begin
                        st <= ST_STOP;
                    end
                end
                ST_STOP: if (slot_end) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // SDA drive: changes only at mid-low, except for start and stop edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_low <= 1'b0;
            keep_on <= 1'b0;
        end else begin
            case (st)
                ST_START: if (tick && q == 2'd1) sda_low <= 1'b1;
                ST_ADDR:  if (mid_low) sda_low <= !ADDR_BYTE[bit_n];
                ST_AACK, ST_UPPER, ST_LOWER: if (mid_low) sda_low <= 1'b0;
                ST_MACK1: if (mid_low) sda_low <= 1'b1;
                ST_MACK2: if (mid_low) begin
                    sda_low <= mode_r && !stop_pend;
                    keep_on <= mode_r && !stop_pend;
                end
                ST_STOP: begin
                    if (mid_low)   sda_low <= 1'b1;
                    else if (samp) sda_low <= 1'b0;
                end
                default: sda_low <= 1'b0;
            endcase
        end
    end

    // Address-acknowledge error flag, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                              addr_err <= 1'b0;
        else if (st == ST_IDLE && go)            addr_err <= 1'b0;
        else if (st == ST_AACK && samp && sda_in) addr_err <= 1'b1;
    end

    // Stop request latch; requests while idle are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_IDLE) stop_pend <= 1'b0;
        else if (stop_req)           stop_pend <= 1'b1;
    end

    adc_rd_frame #(.BYTE_W(8), .SMP_W(12)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(samp && (st == ST_UPPER || st == ST_LOWER)),
        .bit_in  (sda_in),
        .up_last (st == ST_UPPER && bit_n == 3'd0),
        .lo_last (st == ST_LOWER && bit_n == 3'd0),
        .data    (smp_data),
        .valid   (smp_valid),
        .fmt_err (fmt_err)
    );

    // R2
    sda_during_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !scl_low && $past(!scl_low) && $past(in_data)) |-> $stable(sda_low));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_low && !sda_low && !smp_valid));

    // R4
    addr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK && samp && sda_in) |=> addr_err);

    // R4
    no_sample_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !smp_valid);

    // R7
    single_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK2 && !mode_r) |-> !sda_low);

    // R9
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> (!mode_r || stop_pend || addr_err));

    // R5
    upper_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK1 && q >= 2'd1) |-> sda_low);

endmodule

// File: tb/sim_adc_stream_reader.sv
module sim_adc_stream_reader;
    localparam int DQ = 8;
    localparam int SCLP = 4 * DQ;
    localparam logic [7:0] EXP_ADDR = 8'h9B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, cont_mode = 1'b0, stop_req = 1'b0;
    logic scl_low, sda_low, busy, smp_valid, fmt_err, addr_err;
    logic [11:0] smp_data;
    logic s_drv = 1'b0;
    wire scl_w = !scl_low;
    wire sda_w = !(sda_low | s_drv);

    always #2 clk = ~clk;

    adc_stream_reader #(.DIV_Q(DQ), .DEV_CODE(4'b1001), .DEV_SEL(3'b101)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .cont_mode(cont_mode), .stop_req(stop_req),
        .sda_in(sda_w), .scl_low(scl_low), .sda_low(sda_low), .busy(busy),
        .smp_data(smp_data), .smp_valid(smp_valid), .fmt_err(fmt_err), .addr_err(addr_err));

    int total = 0, bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model state
    int pcnt = 0;
    logic active = 1'b0, mute = 1'b0, ack_en = 1'b1;
    logic [7:0] rx_addr = 8'h00;
    logic [3:0] hdr = 4'h0;
    logic [11:0] base = 12'h000, step = 12'h000;
    int nstart = 0, nstop = 0, mack1_bad = 0, ack2_low = 0;
    logic last_ack2 = 1'b0;
    int scl_r0 = 0, scl_r1 = 0;

    function automatic logic [15:0] word_of(input int f);
        logic [11:0] s;
        s = base + 12'(f) * step;
        return {hdr, s};
    endfunction

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        nstart++; pcnt = 0; active = 1'b1; mute = 1'b0; rx_addr = 8'h00;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        nstop++; active = 1'b0; s_drv = 1'b0;
    end
    always @(posedge scl_w) begin
        scl_r0 = scl_r1; scl_r1 = cyc;
        if (active) begin
            pcnt++;
            if (pcnt <= 8) rx_addr = {rx_addr[6:0], sda_w};
            else if (pcnt == 9) begin
                if (sda_w) mute = 1'b1;
            end else begin
                if ((pcnt - 10) % 18 == 8 && sda_w) mack1_bad++;
                if ((pcnt - 10) % 18 == 17) begin
                    last_ack2 = sda_w;
                    if (sda_w) mute = 1'b1; else ack2_low++;
                end
            end
        end
    end
    always @(negedge scl_w) if (active) begin
        int n, r;
        logic [15:0] w;
        n = pcnt + 1;
        if (mute || n <= 8) s_drv = 1'b0;
        else if (n == 9) s_drv = (rx_addr == EXP_ADDR) && ack_en;
        else begin
            r = (n - 10) % 18;
            w = word_of((n - 10) / 18);
            if (r < 8) s_drv = !w[15 - r];
            else if (r >= 9 && r <= 16) s_drv = !w[7 - (r - 9)];
            else s_drv = 1'b0;
        end
    end

    // sample monitor
    logic [11:0] got [0:15];
    logic gfmt [0:15];
    int gcyc [0:15];
    int ngot = 0;
    always @(negedge clk) if (rst_n && smp_valid) begin
        if (ngot < 16) begin got[ngot] = smp_data; gfmt[ngot] = fmt_err; gcyc[ngot] = cyc; end
        ngot++;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_go(input logic m);
        @(negedge clk); go = 1'b1; cont_mode = m;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (busy && k < 40000) begin @(negedge clk); k++; end
        repeat (4 * SCLP) @(negedge clk);
    endtask

    task automatic wait_ngot(input int n);
        int k = 0;
        while (ngot < n && k < 40000) begin @(negedge clk); k++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(scl_low == 0 && sda_low == 0, "R1 bus released", {scl_low, sda_low}, 0);
        chk(busy == 0 && smp_valid == 0, "R1 idle outputs", {busy, smp_valid}, 0);
    endtask

    task automatic t_single();
        int s0 = nstart, p0 = nstop, g0 = ngot;
        hdr = 4'h0; base = 12'hA5C; step = 12'h000; ack_en = 1'b1; mack1_bad = 0;
        pulse_go(1'b0);
        wait_idle();
        chk(rx_addr == EXP_ADDR, "R2 address byte", rx_addr, EXP_ADDR);
        chk(nstart - s0 == 1, "R2 one start", nstart - s0, 1);
        chk(scl_r1 - scl_r0 == SCLP, "R3 scl period", scl_r1 - scl_r0, SCLP);
        chk(mack1_bad == 0, "R5 upper ack low", mack1_bad, 0);
        chk(ngot - g0 == 1, "R7 one sample", ngot - g0, 1);
        chk(got[g0] == 12'hA5C, "R6 sample value", got[g0], 12'hA5C);
        chk(gfmt[g0] == 0, "R6 fmt clear", gfmt[g0], 0);
        chk(last_ack2 == 1, "R7 lower nak", last_ack2, 1);
        chk(nstop - p0 == 1 && !busy, "R7 stop and idle", nstop - p0, 1);
        chk(scl_low == 0 && sda_low == 0, "R1 released after read", {scl_low, sda_low}, 0);
    endtask

    task automatic t_cont();
        int s0 = nstart, g0 = ngot, a0;
        hdr = 4'h0; base = 12'h100; step = 12'h123; mack1_bad = 0; ack2_low = 0;
        pulse_go(1'b1);
        wait_ngot(g0 + 3);
        pulse_stop();
        wait_idle();
        a0 = ack2_low;
        chk(ngot - g0 == 3, "R9 sample count", ngot - g0, 3);
        for (int i = 0; i < 3; i++)
            chk(got[g0 + i] == 12'h100 + 12'(i) * 12'h123, "R8 stream value",
                got[g0 + i], 12'h100 + 12'(i) * 12'h123);
        chk(nstart - s0 == 1, "R8 no repeated start", nstart - s0, 1);
        chk(a0 == 2, "R8 lower acks low", a0, 2);
        chk(gcyc[g0 + 1] - gcyc[g0] == 18 * SCLP, "R8 sample spacing",
            gcyc[g0 + 1] - gcyc[g0], 18 * SCLP);
        chk(last_ack2 == 1 && !busy, "R9 nak then stop", last_ack2, 1);
    endtask

    task automatic t_addr_nak();
        int p0 = nstop, g0 = ngot;
        base = 12'h777; ack_en = 1'b0;
        pulse_go(1'b0);
        wait_idle();
        chk(addr_err == 1, "R4 addr_err set", addr_err, 1);
        chk(ngot == g0, "R4 no sample", ngot - g0, 0);
        chk(nstop - p0 == 1 && !busy, "R4 stop and idle", nstop - p0, 1);
        repeat (10) @(negedge clk);
        chk(addr_err == 1, "R11 flag held", addr_err, 1);
        ack_en = 1'b1;
        pulse_go(1'b0);
        repeat (2) @(negedge clk);
        chk(addr_err == 0, "R11 flag cleared", addr_err, 0);
        wait_idle();
        chk(ngot - g0 == 1 && got[g0] == 12'h777, "R11 read after clear", got[g0], 12'h777);
    endtask

    task automatic t_fmt();
        int g0 = ngot;
        hdr = 4'h5; base = 12'h3C7; step = 12'h000;
        pulse_go(1'b0);
        wait_idle();
        chk(got[g0] == 12'h3C7, "R6 header stripped", got[g0], 12'h3C7);
        chk(gfmt[g0] == 1, "R6 fmt flagged", gfmt[g0], 1);
        hdr = 4'h0;
    endtask

    task automatic t_ignored();
        int s0, g0;
        base = 12'h010; step = 12'h001;
        pulse_stop();
        repeat (20) @(negedge clk);
        s0 = nstart; g0 = ngot; ack2_low = 0;
        pulse_go(1'b1);
        repeat (3 * SCLP) @(negedge clk);
        pulse_go(1'b0);
        wait_ngot(g0 + 2);
        pulse_stop();
        wait_idle();
        chk(ack2_low == 1, "R10 idle stop ignored", ack2_low, 1);
        chk(ngot - g0 == 2, "R10 stream continued", ngot - g0, 2);
        chk(nstart - s0 == 1, "R10 go while busy ignored", nstart - s0, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_cont();
        t_addr_nak();
        t_fmt();
        t_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule